// File: doc/BRIEF.md
# Speculative Register Producer Map

This block tracks, for every architectural register, which in-flight instruction will deliver that register's next value. An entry names the producer by its reorder-buffer tag and by the index of the output operand within that producer. An entry marked not-valid is the null producer: the value already sits in the architected register file. Each entry also carries the cycle count at which it was written.

Two complete copies of the table are held side by side. One follows the correct path and the other follows execution down a misspeculated path. A per-register select bit picks which copy a lookup returns. Rename logic writes into either copy. Operand fetch reads through two independent combinational ports. When a misspeculation is resolved, one pulse on the clear input drops every select bit in a single cycle, and every lookup falls back to the correct-path copy. The speculative copy is neither copied back nor erased.

Top module: `prodmap_top`

## Requirements
- R1: After reset, or in the cycle after `init_i` is high, every lookup returns valid 0, tag 0, operand 0 and timestamp 0, and every select bit is clear. `init_i` wins over a write or a clear in the same cycle.
- R2: A write with `wr_spec_i` = 0 stores valid, tag, operand and `now_i` into the correct-path copy of `wr_reg_i` only, and leaves that register's select bit unchanged.
- R3: A write with `wr_spec_i` = 1 stores valid, tag, operand and `now_i` into the speculative copy of `wr_reg_i` only, and sets that register's select bit.
- R4: A lookup of a register returns the speculative copy's valid, tag, operand and timestamp when its select bit is set, and the correct-path copy's values otherwise.
- R5: A write with `wr_valid_i` = 0 stores a null producer: a later lookup of that copy returns valid 0, tag 0 and operand 0, whatever tag and operand were driven.
- R6: `clr_spec_i` = 1 clears all select bits in one cycle. From the next cycle every lookup returns the correct-path copy, including correct-path writes made while the register was selected speculative.
- R7: When `clr_spec_i` and a speculative write fall in the same cycle, the written register's select bit ends clear, so its lookup returns the correct-path copy.
- R8: A write is not forwarded. A lookup of the register being written returns the old contents until the clock edge that performs the write.
- R9: The two read ports are independent. Each returns the entry for its own register number in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous re-initialise of both copies and all select bits |
| clr_spec_i | input | 1 | Clear all select bits (misspeculation recovery) |
| wr_en_i | input | 1 | Write strobe |
| wr_spec_i | input | 1 | 1: write the speculative copy, 0: write the correct-path copy |
| wr_reg_i | input | $clog2(NREG) | Register number written |
| wr_valid_i | input | 1 | 1: producer in flight, 0: null producer |
| wr_tag_i | input | TAG_W | Producer reorder-buffer tag |
| wr_op_i | input | OP_W | Producer output-operand index |
| now_i | input | TS_W | Current cycle count, stored as the timestamp |
| rd_reg_i | input | NRD x $clog2(NREG) | Register number per read port |
| rd_valid_o | output | NRD | Producer-valid per read port |
| rd_tag_o | output | NRD x TAG_W | Producer tag per read port |
| rd_op_o | output | NRD x OP_W | Output-operand index per read port |
| rd_ts_o | output | NRD x TS_W | Creation timestamp per read port |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a clear that meets a speculative write. The other is a correct-path write that lands on a register whose lookups currently come from the speculative copy. The stimulus builds a mixed table in which every third register is speculative. It then rewrites a selected register on the correct path, showing that the lookup is unchanged until the clear exposes the new value. Finally it pulses clear together with a speculative write to a register that holds a known correct-path entry. Throughout, a read port is parked on the register being written during the write cycle, to check the no-forwarding rule.

// File: rtl/prodmap_pkg.sv
package prodmap_pkg;
   typedef enum logic {
      CPY_ARCH = 1'b0,
      CPY_SPEC = 1'b1
   } copy_e;

   localparam int unsigned NCOPY = 2;

   // Pick the write enable of one copy from the write strobe and mode.
   function automatic logic copy_we(input logic we, input logic spec, input copy_e c);
      return we && (spec == logic'(c));
   endfunction
endpackage

// File: rtl/prodmap_bank.sv
module prodmap_bank #(
   parameter int unsigned NREG  = 32,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned OP_W  = 2,
   parameter int unsigned TS_W  = 16,
   parameter int unsigned NRD   = 2,
   localparam int unsigned RW   = $clog2(NREG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          init_i,
   input  logic                          we_i,
   input  logic [RW-1:0]                 wr_reg_i,
   input  logic                          wr_valid_i,
   input  logic [TAG_W-1:0]              wr_tag_i,
   input  logic [OP_W-1:0]               wr_op_i,
   input  logic [TS_W-1:0]               wr_ts_i,
   input  logic [NRD-1:0][RW-1:0]        rd_reg_i,
   output logic [NRD-1:0]                rd_valid_o,
   output logic [NRD-1:0][TAG_W-1:0]     rd_tag_o,
   output logic [NRD-1:0][OP_W-1:0]      rd_op_o,
   output logic [NRD-1:0][TS_W-1:0]      rd_ts_o
);
   logic [NREG-1:0]             v_q;
   logic [NREG-1:0][TAG_W-1:0]  tag_q;
   logic [NREG-1:0][OP_W-1:0]   op_q;
   logic [NREG-1:0][TS_W-1:0]   ts_q;

   // A null producer is normalised to tag 0, operand 0.
   logic [TAG_W-1:0] tag_n;
   logic [OP_W-1:0]  op_n;
   assign tag_n = wr_valid_i ? wr_tag_i : '0;
   assign op_n  = wr_valid_i ? wr_op_i  : '0;

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      logic hit;
      assign hit = we_i && (wr_reg_i == RW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[g]   <= 1'b0;
            tag_q[g] <= '0;
            op_q[g]  <= '0;
            ts_q[g]  <= '0;
         end else if (init_i) begin
            v_q[g]   <= 1'b0;
            tag_q[g] <= '0;
            op_q[g]  <= '0;
            ts_q[g]  <= '0;
         end else if (hit) begin
            v_q[g]   <= wr_valid_i;
            tag_q[g] <= tag_n;
            op_q[g]  <= op_n;
            ts_q[g]  <= wr_ts_i;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic inr;
      assign inr           = (32'(rd_reg_i[p]) < NREG);
      assign rd_valid_o[p] = inr ? v_q[rd_reg_i[p]]   : 1'b0;
      assign rd_tag_o[p]   = inr ? tag_q[rd_reg_i[p]] : '0;
      assign rd_op_o[p]    = inr ? op_q[rd_reg_i[p]]  : '0;
      assign rd_ts_o[p]    = inr ? ts_q[rd_reg_i[p]]  : '0;
   end
endmodule

// File: rtl/prodmap_selvec.sv
module prodmap_selvec #(
   parameter int unsigned NREG = 32,
   localparam int unsigned RW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            init_i,
   input  logic            clr_i,
   input  logic            set_i,
   input  logic [RW-1:0]   set_reg_i,
   output logic [NREG-1:0] sel_o
);
   // Clear and init both override a set in the same cycle.
   for (genvar g = 0; g < NREG; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_o[g] <= 1'b0;
         else if (init_i || clr_i)
            sel_o[g] <= 1'b0;
         else if (set_i && (set_reg_i == RW'(g)))
            sel_o[g] <= 1'b1;
      end
   end
endmodule

// File: rtl/prodmap_top.sv
module prodmap_top
   import prodmap_pkg::*;
#(
   parameter int unsigned NREG  = 32,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned OP_W  = 2,
   parameter int unsigned TS_W  = 16,
   parameter int unsigned NRD   = 2,
   localparam int unsigned RW   = $clog2(NREG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          init_i,
   input  logic                          clr_spec_i,
   input  logic                          wr_en_i,
   input  logic                          wr_spec_i,
   input  logic [RW-1:0]                 wr_reg_i,
   input  logic                          wr_valid_i,
   input  logic [TAG_W-1:0]              wr_tag_i,
   input  logic [OP_W-1:0]               wr_op_i,
   input  logic [TS_W-1:0]               now_i,
   input  logic [NRD-1:0][RW-1:0]        rd_reg_i,
   output logic [NRD-1:0]                rd_valid_o,
   output logic [NRD-1:0][TAG_W-1:0]     rd_tag_o,
   output logic [NRD-1:0][OP_W-1:0]      rd_op_o,
   output logic [NRD-1:0][TS_W-1:0]      rd_ts_o
);
   if (NREG < 2)  begin : g_bad_nreg $error("NREG must be at least 2"); end
   if (TAG_W < 1) begin : g_bad_tag  $error("TAG_W must be at least 1"); end
   if (OP_W < 1)  begin : g_bad_op   $error("OP_W must be at least 1"); end
   if (TS_W < 1)  begin : g_bad_ts   $error("TS_W must be at least 1"); end
   if (NRD < 1)   begin : g_bad_nrd  $error("NRD must be at least 1"); end

   logic [NREG-1:0] sel_q;

   logic [NCOPY-1:0][NRD-1:0]            b_valid;
   logic [NCOPY-1:0][NRD-1:0][TAG_W-1:0] b_tag;
   logic [NCOPY-1:0][NRD-1:0][OP_W-1:0]  b_op;
   logic [NCOPY-1:0][NRD-1:0][TS_W-1:0]  b_ts;

   for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      logic we;
      assign we = copy_we(wr_en_i, wr_spec_i, copy_e'(c));
      prodmap_bank #(
         .NREG(NREG), .TAG_W(TAG_W), .OP_W(OP_W), .TS_W(TS_W), .NRD(NRD)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .init_i     (init_i),
         .we_i       (we),
         .wr_reg_i   (wr_reg_i),
         .wr_valid_i (wr_valid_i),
         .wr_tag_i   (wr_tag_i),
         .wr_op_i    (wr_op_i),
         .wr_ts_i    (now_i),
         .rd_reg_i   (rd_reg_i),
         .rd_valid_o (b_valid[c]),
         .rd_tag_o   (b_tag[c]),
         .rd_op_o    (b_op[c]),
         .rd_ts_o    (b_ts[c])
      );
   end

   prodmap_selvec #(.NREG(NREG)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_i    (init_i),
      .clr_i     (clr_spec_i),
      .set_i     (wr_en_i && wr_spec_i),
      .set_reg_i (wr_reg_i),
      .sel_o     (sel_q)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_port
      logic  inr;
      copy_e pick;
      assign inr  = (32'(rd_reg_i[p]) < NREG);
      assign pick = (inr && sel_q[rd_reg_i[p]]) ? CPY_SPEC : CPY_ARCH;
      assign rd_valid_o[p] = b_valid[pick][p];
      assign rd_tag_o[p]   = b_tag[pick][p];
      assign rd_op_o[p]    = b_op[pick][p];
      assign rd_ts_o[p]    = b_ts[pick][p];
   end
endmodule

// File: rtl/prodmap_chk.sv
module prodmap_chk #(
   parameter int unsigned NREG  = 32,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned OP_W  = 2,
   parameter int unsigned TS_W  = 16,
   parameter int unsigned NRD   = 2,
   localparam int unsigned RW   = $clog2(NREG)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          init_i,
   input logic                          clr_spec_i,
   input logic                          wr_en_i,
   input logic                          wr_spec_i,
   input logic [RW-1:0]                 wr_reg_i,
   input logic [NRD-1:0][RW-1:0]        rd_reg_i,
   input logic [NRD-1:0]                rd_valid_o,
   input logic [NRD-1:0][TAG_W-1:0]     rd_tag_o,
   input logic [NRD-1:0][OP_W-1:0]      rd_op_o,
   input logic [NRD-1:0][TS_W-1:0]      rd_ts_o,
   input logic [NREG-1:0]               sel_q
);
   logic inr;
   assign inr = (32'(wr_reg_i) < NREG);

   a_r1_init_null: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (rd_valid_o == '0 && rd_ts_o == '0 && sel_q == '0));

   a_r3_spec_sets_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_spec_i && !clr_spec_i && !init_i && inr)
         |=> sel_q[$past(wr_reg_i)]);

   a_r2_arch_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_spec_i && !clr_spec_i && !init_i && inr)
         |=> sel_q[$past(wr_reg_i)] == $past(sel_q[wr_reg_i]));

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_spec_i |=> (sel_q == '0));

   for (genvar p = 0; p < NRD; p++) begin : g_p
      a_r5_null_fields: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_valid_o[p] |-> (rd_tag_o[p] == '0 && rd_op_o[p] == '0));
   end

   if (NRD >= 2) begin : g_two
      a_r9_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_reg_i[0] == rd_reg_i[1]) |->
            (rd_valid_o[0] == rd_valid_o[1] && rd_tag_o[0] == rd_tag_o[1] &&
             rd_op_o[0] == rd_op_o[1] && rd_ts_o[0] == rd_ts_o[1]));
   end
endmodule

bind prodmap_top prodmap_chk #(
   .NREG(NREG), .TAG_W(TAG_W), .OP_W(OP_W), .TS_W(TS_W), .NRD(NRD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_i     (init_i),
   .clr_spec_i (clr_spec_i),
   .wr_en_i    (wr_en_i),
   .wr_spec_i  (wr_spec_i),
   .wr_reg_i   (wr_reg_i),
   .rd_reg_i   (rd_reg_i),
   .rd_valid_o (rd_valid_o),
   .rd_tag_o   (rd_tag_o),
   .rd_op_o    (rd_op_o),
   .rd_ts_o    (rd_ts_o),
   .sel_q      (sel_q)
);

// File: tb/prodmap_top_test.sv
`timescale 1ns/1ps
module prodmap_top_test;
   localparam int NREG = 32, TAG_W = 6, OP_W = 2, TS_W = 16, NRD = 2;
   localparam int RW = $clog2(NREG);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_i = 0, clr_spec_i = 0, wr_en_i = 0, wr_spec_i = 0, wr_valid_i = 0;
   logic [RW-1:0] wr_reg_i = '0;
   logic [TAG_W-1:0] wr_tag_i = '0;
   logic [OP_W-1:0] wr_op_i = '0;
   logic [TS_W-1:0] nowc = '0;
   logic [NRD-1:0][RW-1:0] rd_reg_i = '0;
   logic [NRD-1:0] rd_valid_o;
   logic [NRD-1:0][TAG_W-1:0] rd_tag_o;
   logic [NRD-1:0][OP_W-1:0] rd_op_o;
   logic [NRD-1:0][TS_W-1:0] rd_ts_o;

   always #2 clk = ~clk;
   always @(posedge clk) nowc <= nowc + 1'b1;

   prodmap_top #(.NREG(NREG), .TAG_W(TAG_W), .OP_W(OP_W), .TS_W(TS_W), .NRD(NRD)) uut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .clr_spec_i(clr_spec_i),
      .wr_en_i(wr_en_i), .wr_spec_i(wr_spec_i), .wr_reg_i(wr_reg_i),
      .wr_valid_i(wr_valid_i), .wr_tag_i(wr_tag_i), .wr_op_i(wr_op_i),
      .now_i(nowc), .rd_reg_i(rd_reg_i), .rd_valid_o(rd_valid_o),
      .rd_tag_o(rd_tag_o), .rd_op_o(rd_op_o), .rd_ts_o(rd_ts_o));

   // Reference model
   logic            m_sel [NREG];
   logic            a_v [NREG], s_v [NREG];
   logic [TAG_W-1:0] a_t [NREG], s_t [NREG];
   logic [OP_W-1:0]  a_o [NREG], s_o [NREG];
   logic [TS_W-1:0]  a_s [NREG], s_s [NREG];

   int nchk = 0, nfail = 0;

   task automatic m_clear_all();
      for (int r = 0; r < NREG; r++) begin
         m_sel[r] = 0; a_v[r] = 0; s_v[r] = 0; a_t[r] = 0; s_t[r] = 0;
         a_o[r] = 0; s_o[r] = 0; a_s[r] = 0; s_s[r] = 0;
      end
   endtask

   task automatic chk(input int p, input int r, input string req);
      logic ev; logic [TAG_W-1:0] et; logic [OP_W-1:0] eo; logic [TS_W-1:0] es;
      ev = m_sel[r] ? s_v[r] : a_v[r];
      et = m_sel[r] ? s_t[r] : a_t[r];
      eo = m_sel[r] ? s_o[r] : a_o[r];
      es = m_sel[r] ? s_s[r] : a_s[r];
      nchk++;
      if (rd_valid_o[p] !== ev || rd_tag_o[p] !== et || rd_op_o[p] !== eo || rd_ts_o[p] !== es) begin
         nfail++;
         $display("FAIL %s port%0d reg%0d: got v=%0b t=%0d o=%0d ts=%0d exp v=%0b t=%0d o=%0d ts=%0d",
            req, p, r, rd_valid_o[p], rd_tag_o[p], rd_op_o[p], rd_ts_o[p], ev, et, eo, es);
      end
   endtask

   // Both ports sweep the whole table, port 1 in reverse order (R9).
   task automatic chk_all(input string req);
      for (int r = 0; r < NREG; r++) begin
         rd_reg_i[0] = RW'(r);
         rd_reg_i[1] = RW'(NREG - 1 - r);
         #0.5;
         chk(0, r, req);
         chk(1, NREG - 1 - r, {req, "/R9"});
      end
   endtask

   // One clocked operation; port 0 looks at the written register during the write (R8).
   task automatic step(input logic ini, input logic clr, input logic we, input logic sp,
                       input int r, input logic v, input int tg, input int op);
      logic [TS_W-1:0] t;
      @(negedge clk);
      init_i = ini; clr_spec_i = clr; wr_en_i = we; wr_spec_i = sp;
      wr_reg_i = RW'(r); wr_valid_i = v; wr_tag_i = TAG_W'(tg); wr_op_i = OP_W'(op);
      rd_reg_i[0] = RW'(r);
      t = nowc;
      #0.5;
      if (we) chk(0, r, "R8");
      @(posedge clk);
      if (ini) m_clear_all();
      else begin
         if (we && sp) begin
            s_v[r] = v; s_t[r] = v ? TAG_W'(tg) : '0; s_o[r] = v ? OP_W'(op) : '0; s_s[r] = t;
            if (!clr) m_sel[r] = 1;
         end else if (we) begin
            a_v[r] = v; a_t[r] = v ? TAG_W'(tg) : '0; a_o[r] = v ? OP_W'(op) : '0; a_s[r] = t;
         end
         if (clr) for (int k = 0; k < NREG; k++) m_sel[k] = 0;
      end
      #0.5;
      init_i = 0; clr_spec_i = 0; wr_en_i = 0; wr_spec_i = 0;
   endtask

   initial begin
      #400000;
      nfail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      m_clear_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_all("R1");

      // Correct-path fill; every seventh register gets a null producer (R2, R5)
      for (int r = 0; r < NREG; r++)
         step(0, 0, 1, 0, r, (r % 7) != 6, (r * 5 + 3) % 64, r % 4);
      chk_all("R2/R5");

      // Speculative writes on every third register (R3, R4)
      for (int r = 0; r < NREG; r += 3)
         step(0, 0, 1, 1, r, 1, (r * 11 + 1) % 64, (r + 1) % 4);
      step(0, 0, 1, 1, 4, 0, 63, 3);   // null speculative write (R5)
      chk_all("R3/R4");

      // Correct-path write to a speculative-selected register: lookup stays speculative (R2, R4)
      step(0, 0, 1, 0, 3, 1, 42, 1);
      chk_all("R2/R4");

      // Clear: everything back on the correct path, including reg 3's new entry (R6)
      step(0, 1, 0, 0, 0, 0, 0, 0);
      chk_all("R6");

      // Clear together with a speculative write (R7)
      step(0, 0, 1, 1, 9, 1, 17, 2);
      step(0, 1, 1, 1, 5, 1, 33, 3);
      chk_all("R7");

      // Init colliding with a speculative write and a clear (R1)
      step(0, 0, 1, 1, 12, 1, 50, 1);
      step(1, 1, 1, 1, 12, 1, 51, 2);
      chk_all("R1");

      // Refill after init to confirm the table works again (R2, R3)
      step(0, 0, 1, 0, 7, 1, 7, 3);
      step(0, 0, 1, 1, 7, 1, 9, 1);
      chk_all("R3");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule